// File: doc/BRIEF.md
# Message-Embedding Polynomial Adder

This block performs the last coefficient-wise step of a lattice encryption. It walks a polynomial of `N` coefficients and computes `v[w] = (psum[w] + e2[w] + mu[w]) mod Q` for each one. The message term `mu` is not stored anywhere. It is decoded on the fly from a packed message vector: a one bit becomes `(Q+1)/2`, which is 1665 for Q = 3329, and a zero bit becomes 0.

The partial sum and the noise polynomial sit in two different memory banks. Each bank gets its own synchronous read port, so neither port ever sees two reads in one cycle. Both ports read with a latency of one cycle. Each result is written back over the partial-sum slot it came from, in the same cycle the read data for that slot arrives.

A run starts with a one-cycle `start` while the block is idle. It ends with a one-cycle `done` pulse.

Top module: `msg_poly_adder`

## Requirements
- R1: While reset is held, and directly after it, `busy`, `done`, `wr_en`, `psum_rd_en` and `e2_rd_en` are all 0.
- R2: A `start` accepted at a clock edge while idle makes both read ports issue index 0 in the following cycle. The index then rises by one per cycle up to N-1. Both ports carry the same index in every cycle.
- R3: The message term for coefficient w is taken from `msg[w]`, which is bit (w mod 8) of byte (w / 8), with byte b held in `msg[8b+7:8b]`. A set bit contributes (Q+1)/2, which is 1665 for Q = 3329. A clear bit contributes 0.
- R4: For operands below Q, `wr_data` equals `(psum + e2 + mu) mod Q` and is always below Q.
- R5: The write for index k happens one cycle after both ports issued index k, with `wr_addr` = k. The result therefore replaces the partial-sum slot it was read from, with no index shift.
- R6: `done` is high for exactly one cycle: the cycle after the write of index N-1. `busy` is high from the first read through the last write and low when `done` is high.
- R7: A `start` that arrives while `busy` is high is ignored. The running sweep continues unchanged and performs exactly N writes.
- R8: Worst-case operands (psum = e2 = Q-1 with a set message bit) reduce correctly. Both conditional subtractions of Q are exercised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep when idle |
| msg | input | N | Packed message, bit w selects the term for coefficient w |
| psum_rd_en | output | 1 | Read enable, partial-sum bank |
| psum_rd_addr | output | $clog2(N) | Read index, partial-sum bank |
| psum_rd_data | input | CW | Partial-sum data, one cycle after the read |
| e2_rd_en | output | 1 | Read enable, noise bank |
| e2_rd_addr | output | $clog2(N) | Read index, noise bank |
| e2_rd_data | input | CW | Noise data, one cycle after the read |
| wr_en | output | 1 | Write enable into the partial-sum bank |
| wr_addr | output | $clog2(N) | Write index |
| wr_data | output | CW | Reduced sum |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults: N = 256, Q = 3329 and CW = 12. These are the values that reach index 255 and the wrap of an 8-bit index. They also test the byte/bit mapping of a 32-byte message against the real modulus. Q = 3329 puts the worst-case three-operand sum close to 3Q, so both subtraction stages are forced. Back-to-back sweeps apply the result in place and feed it into the next sweep as a new partial sum. A `start` raised mid-sweep checks that the sweep is not disturbed.

// File: rtl/msg_add_pkg.sv
package msg_add_pkg;

  // Message bit to its additive term: (q+1)/2 when set, zero otherwise.
  function automatic logic [15:0] msg_term(input logic bit_v, input logic [15:0] q);
    msg_term = bit_v ? ((q + 16'd1) >> 1) : 16'd0;
  endfunction

  // Three operands each below q; the sum is below 3q, so two trial subtractions suffice.
  function automatic logic [15:0] add3_mod(input logic [15:0] a, input logic [15:0] b,
                                           input logic [15:0] c, input logic [15:0] q);
    logic [17:0] s;
    s = {2'b00, a} + {2'b00, b} + {2'b00, c};
    if (s >= {2'b00, q}) s = s - {2'b00, q};
    if (s >= {2'b00, q}) s = s - {2'b00, q};
    add3_mod = s[15:0];
  endfunction

endpackage

// File: rtl/madd_sequencer.sv
module madd_sequencer #(
  parameter int N  = 256,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          issuing,
  output logic [AW-1:0] rd_idx,
  output logic          wr_vld,
  output logic [AW-1:0] wr_idx,
  output logic          busy,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  logic accept;
  logic last_write;

  assign busy       = issuing | wr_vld;
  assign accept     = start & ~busy;
  assign last_write = wr_vld & (wr_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issuing <= 1'b0;
      rd_idx  <= '0;
      wr_vld  <= 1'b0;
      wr_idx  <= '0;
      done    <= 1'b0;
    end else begin
      if (accept) begin
        issuing <= 1'b1;
        rd_idx  <= '0;
      end else if (issuing) begin
        if (rd_idx == LAST) issuing <= 1'b0;
        rd_idx <= rd_idx + 1'b1;
      end
      // one stage, matching the one-cycle read latency of both banks
      wr_vld <= issuing;
      wr_idx <= rd_idx;
      done   <= last_write;
    end
  end

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issuing && $past(issuing)) |-> (rd_idx == $past(rd_idx) + 1'b1));

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_vld) && ($past(wr_idx) == LAST) && !busy));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && issuing && rd_idx != LAST) |=> (issuing && rd_idx != '0));

endmodule

// File: rtl/madd_lane.sv
module madd_lane
  import msg_add_pkg::*;
#(
  parameter int N  = 256,
  parameter int Q  = 3329,
  parameter int CW = 12,
  parameter int AW = 8
) (
  input  logic [N-1:0]  msg,
  input  logic [AW-1:0] idx,
  input  logic [CW-1:0] psum,
  input  logic [CW-1:0] e2,
  output logic          msg_bit,
  output logic [CW-1:0] mu_val,
  output logic [CW-1:0] result
);
  localparam logic [15:0] QV = 16'(Q);

  logic [15:0] mu16;
  logic [15:0] sum16;

  assign msg_bit = msg[idx];
  assign mu16    = msg_term(msg_bit, QV);
  assign mu_val  = mu16[CW-1:0];
  assign sum16   = add3_mod(16'(psum), 16'(e2), mu16, QV);
  assign result  = sum16[CW-1:0];

endmodule

// File: rtl/msg_poly_adder.sv
module msg_poly_adder #(
  parameter  int N  = 256,
  parameter  int Q  = 3329,
  parameter  int CW = 12,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [N-1:0]  msg,
  output logic          psum_rd_en,
  output logic [AW-1:0] psum_rd_addr,
  input  logic [CW-1:0] psum_rd_data,
  output logic          e2_rd_en,
  output logic [AW-1:0] e2_rd_addr,
  input  logic [CW-1:0] e2_rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [CW-1:0] wr_data,
  output logic          busy,
  output logic          done
);
  logic          issuing;
  logic [AW-1:0] rd_idx;
  logic          wr_vld;
  logic [AW-1:0] wr_idx;
  logic          msg_bit;
  logic [CW-1:0] mu_val;
  logic [CW-1:0] result;

  madd_sequencer #(.N(N), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .issuing(issuing), .rd_idx(rd_idx),
    .wr_vld(wr_vld), .wr_idx(wr_idx),
    .busy(busy), .done(done)
  );

  madd_lane #(.N(N), .Q(Q), .CW(CW), .AW(AW)) u_lane (
    .msg(msg), .idx(wr_idx),
    .psum(psum_rd_data), .e2(e2_rd_data),
    .msg_bit(msg_bit), .mu_val(mu_val), .result(result)
  );

  // two banks, one read each per cycle, same index
  assign psum_rd_en   = issuing;
  assign psum_rd_addr = rd_idx;
  assign e2_rd_en     = issuing;
  assign e2_rd_addr   = rd_idx;

  // write index equals the index whose data is on the read buses now
  assign wr_en   = wr_vld;
  assign wr_addr = wr_idx;
  assign wr_data = result;

  // R5
  write_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(psum_rd_en) && $past(e2_rd_en) && wr_addr == $past(psum_rd_addr)));

  // R4
  result_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && psum_rd_data < CW'(Q) && e2_rd_data < CW'(Q)) |-> (wr_data < CW'(Q)));

  // R3
  mu_tracks_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (msg_bit ? (mu_val == CW'((Q + 1) / 2)) : (mu_val == '0)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!busy && !done && !wr_en && !psum_rd_en && !e2_rd_en));

endmodule

// File: tb/tb_msg_poly_adder.sv
module tb_msg_poly_adder;
  localparam int N = 256;
  localparam int Q = 3329;
  localparam int CW = 12;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] msg = '0;
  logic psum_rd_en, e2_rd_en, wr_en, busy, done;
  logic [AW-1:0] psum_rd_addr, e2_rd_addr, wr_addr;
  logic [CW-1:0] psum_rd_data, e2_rd_data, wr_data;

  logic [CW-1:0] mem_p [N];
  logic [CW-1:0] mem_e [N];
  int orig_p [N];
  int orig_e [N];

  int checks = 0;
  int errors = 0;
  int writes_seen;

  always #10 clk = ~clk;

  msg_poly_adder #(.N(N), .Q(Q), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg(msg),
    .psum_rd_en(psum_rd_en), .psum_rd_addr(psum_rd_addr), .psum_rd_data(psum_rd_data),
    .e2_rd_en(e2_rd_en), .e2_rd_addr(e2_rd_addr), .e2_rd_data(e2_rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  // bank models: one-cycle synchronous read, write into the partial-sum bank
  always @(posedge clk) begin
    if (psum_rd_en) psum_rd_data <= mem_p[psum_rd_addr];
    if (e2_rd_en) e2_rd_data <= mem_e[e2_rd_addr];
    if (wr_en) mem_p[wr_addr] <= wr_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_val(input int p, input int e, input bit b);
    int t;
    t = p + e + (b ? 1665 : 0);
    return t % Q;
  endfunction

  // mode 0 zero, 1 all max, 2 random, 3 keep current partial sums
  task automatic load(input int mode);
    for (int i = 0; i < N; i++) begin
      int pv, ev;
      pv = (mode == 0) ? 0 : (mode == 1) ? Q - 1 : (mode == 3) ? int'(mem_p[i]) : int'($urandom_range(0, Q - 1));
      ev = (mode == 0) ? 0 : (mode == 1) ? Q - 1 : int'($urandom_range(0, Q - 1));
      mem_p[i] <= CW'(pv);
      mem_e[i] <= CW'(ev);
      orig_p[i] = pv;
      orig_e[i] = ev;
    end
    @(posedge clk);
  endtask

  // one sweep, checked on every negedge against the expected schedule
  task automatic sweep(input logic [N-1:0] m, input int poke_at);
    @(negedge clk);
    msg = m;
    start = 1'b1;
    writes_seen = 0;
    for (int t = 0; t <= N + 1; t++) begin
      @(negedge clk);
      start = 1'b0;
      chk(psum_rd_en == (t <= N - 1) && e2_rd_en == (t <= N - 1), "R2 rd_en", int'(psum_rd_en), int'(t <= N - 1));
      if (t <= N - 1)
        chk(int'(psum_rd_addr) == t && int'(e2_rd_addr) == t, "R2 rd_addr", int'(psum_rd_addr), t);
      chk(wr_en == (t >= 1 && t <= N), "R5 wr_en", int'(wr_en), int'(t >= 1 && t <= N));
      if (wr_en) writes_seen++;
      if (t >= 1 && t <= N) begin
        int idx, exp;
        idx = t - 1;
        exp = ref_val(orig_p[idx], orig_e[idx], m[idx]);
        chk(int'(wr_addr) == idx, "R5 wr_addr", int'(wr_addr), idx);
        chk(int'(wr_data) == exp, (orig_p[idx] == Q - 1 && orig_e[idx] == Q - 1) ? "R8 wr_data" : "R4/R3 wr_data", int'(wr_data), exp);
      end
      chk(done == (t == N + 1), "R6 done", int'(done), int'(t == N + 1));
      chk(busy == (t <= N), "R6 busy", int'(busy), int'(t <= N));
      if (t == poke_at) start = 1'b1;
    end
    chk(writes_seen == N, "R7 write count", writes_seen, N);
    @(negedge clk);
    chk(!done && !busy, "R6 single pulse", int'(done), 0);
    // in-place result: bank now holds the sums
    for (int i = 0; i < N; i++)
      chk(int'(mem_p[i]) == ref_val(orig_p[i], orig_e[i], m[i]), "R5 in place", int'(mem_p[i]), ref_val(orig_p[i], orig_e[i], m[i]));
  endtask

  initial begin
    logic [N-1:0] rm;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_en && !psum_rd_en && !e2_rd_en, "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_en && !psum_rd_en && !e2_rd_en, "R1 after reset", int'(busy), 0);

    load(0);
    sweep('0, -1);                       // R4 zero operands, zero message

    load(0);
    sweep({N{1'b1}}, -1);                // R3 every term 1665

    load(1);
    sweep({N{1'b1}}, -1);                // R8 worst case: 3328+3328+1665 -> 1663

    load(2);
    for (int i = 0; i < N / 32; i++) rm[i*32 +: 32] = $urandom;
    sweep(rm, 100);                      // R7 start poked mid-sweep

    load(3);
    sweep({(N/2){2'b01}}, 0);            // R3 alternating bits, R7 poke right after accept

    load(2);
    rm = '0;
    rm[8*31 + 7] = 1'b1;                 // R3 bit 7 of byte 31
    rm[8*1 + 0] = 1'b1;                  // R3 bit 0 of byte 1
    sweep(rm, N - 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule